// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block keeps a position count from two encoder lines, A and B, which reach it already synchronised to its clock. A two-bit rule selector chooses how the lines are read. Rule 0 takes direction from the level of B at each A edge. Rule 1 treats A as an up pulse and B as a down pulse. Rule 2 counts A edges only while B is low. Rule 3 is full four-edge quadrature decoding. In rules 0 and 1 an edge-select field picks which transitions count. In rules 2 and 3 both transitions always count.

The configuration (rule, edge select and retain flag) is captured only while the enable is low. A running block therefore ignores changes to it until the next disable and enable. When retain is clear, the counter is cleared while disabled, and the preset value is copied into it on the enable's rising edge. When retain is set, the count is held through the disable and resumes from that value. Every step produces a one-cycle up or down strobe, along with a wrap strobe whenever the count rolls over.

Top module: `qenc_counter`

## Requirements
- R1: While rst_n is low the count is 0 and all four strobes are low.
- R2: Rule 0 (mode=00): each selected edge of A steps the count by one; up if enc_b is low in that cycle, down if enc_b is high. B edges do nothing.
- R3: Rule 1 (mode=01): a selected edge of A steps up and a selected edge of B steps down; when both occur in the same cycle the count and strobes are unchanged.
- R4: Rule 2 (mode=10): while enc_b is low a rising edge of A steps down and a falling edge of A steps up; while enc_b is high A edges are ignored.
- R5: Rule 3 (mode=11): an A rise with B low, A fall with B high, B rise with A high or B fall with A low steps up; the mirror cases step down; a cycle where both lines change does nothing.
- R6: edge_sel selects the counted transitions in rules 0 and 1 (00 none, 01 rising, 10 falling, 11 both); in rules 2 and 3 it has no effect and both transitions count.
- R7: mode, edge_sel and keep are taken only in cycles where en is low; changes while en is high have no effect until en has been low again.
- R8: While en is low no counting happens; the count holds if keep is 1 and is cleared to 0 if keep is 0.
- R9: In the first cycle with en high after a low cycle, if the captured keep is 0 the count takes load_val and no step is made; if it is 1 the count is not loaded and edges count as usual.
- R10: The count wraps modulo 2^W; ovf_stb pulses with a step from all ones to 0 and unf_stb with a step from 0 to all ones.
- R11: up_stb and dn_stb pulse for exactly the cycles in which the count moved up or down by one, registered with the new count; never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Count enable |
| mode | input | 2 | Counting rule select |
| edge_sel | input | 2 | Active transitions for rules 0 and 1 |
| keep | input | 1 | Retain count across disable |
| load_val | input | W | Preset copied at enable |
| enc_a | input | 1 | Encoder line A (synchronised) |
| enc_b | input | 1 | Encoder line B (synchronised) |
| count | output | W | Counter value |
| up_stb | output | 1 | Count stepped up |
| dn_stb | output | 1 | Count stepped down |
| ovf_stb | output | 1 | Wrap from all ones to 0 |
| unf_stb | output | 1 | Wrap from 0 to all ones |

## Verification
The bench builds the block with its default width of 16. Presetting the count to 0xFFFF through load_val brings both wrap directions within reach in a handful of cycles, where counting to them would take 65536 cycles. Every rule is driven through its full edge and level combinations, including both lines changing in the same cycle. Configuration changes are made while the block is running to show that they are held off until the next enable.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic [1:0]   edge_sel,
  input  logic         keep,
  input  logic [W-1:0] load_val,
  input  logic         enc_a,
  input  logic         enc_b,
  output logic [W-1:0] count,
  output logic         up_stb,
  output logic         dn_stb,
  output logic         ovf_stb,
  output logic         unf_stb
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic       a_q, b_q, en_q;
  logic [1:0] mode_l, esel_l;
  logic       keep_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      en_q   <= 1'b0;
      mode_l <= 2'b00;
      esel_l <= 2'b00;
      keep_l <= 1'b0;
    end else begin
      a_q  <= enc_a;
      b_q  <= enc_b;
      en_q <= en;
      if (!en) begin
        mode_l <= mode;
        esel_l <= edge_sel;
        keep_l <= keep;
      end
    end
  end

  wire a_r = enc_a & ~a_q;
  wire a_f = ~enc_a & a_q;
  wire b_r = enc_b & ~b_q;
  wire b_f = ~enc_b & b_q;

  wire [1:0] esel_eff = mode_l[1] ? 2'b11 : esel_l;
  wire a_v = (esel_eff[0] & a_r) | (esel_eff[1] & a_f);
  wire b_v = (esel_eff[0] & b_r) | (esel_eff[1] & b_f);
  wire a_chg = a_r | a_f;
  wire b_chg = b_r | b_f;

  logic inc, dec;
  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    case (mode_l)
      2'b00: begin
        inc = a_v & ~enc_b;
        dec = a_v & enc_b;
      end
      2'b01: begin
        inc = a_v & ~b_v;
        dec = b_v & ~a_v;
      end
      2'b10: begin
        inc = ~enc_b & a_f;
        dec = ~enc_b & a_r;
      end
      default: begin
        if (a_chg & ~b_chg) begin
          inc = (a_r & ~enc_b) | (a_f & enc_b);
          dec = (a_r & enc_b) | (a_f & ~enc_b);
        end else if (b_chg & ~a_chg) begin
          inc = (b_r & enc_a) | (b_f & ~enc_a);
          dec = (b_r & ~enc_a) | (b_f & enc_a);
        end
      end
    endcase
  end

  wire start  = en & ~en_q;
  wire do_ld  = start & ~keep_l;
  wire go_up  = en & ~do_ld & inc;
  wire go_dn  = en & ~do_ld & dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      up_stb  <= 1'b0;
      dn_stb  <= 1'b0;
      ovf_stb <= 1'b0;
      unf_stb <= 1'b0;
    end else begin
      up_stb  <= go_up;
      dn_stb  <= go_dn;
      ovf_stb <= go_up & (count == MAXV);
      unf_stb <= go_dn & (count == '0);
      if (!en) begin
        if (!keep) count <= '0;
      end else if (do_ld) begin
        count <= load_val;
      end else if (go_up) begin
        count <= count + 1'b1;
      end else if (go_dn) begin
        count <= count - 1'b1;
      end
    end
  end

endmodule

module qenc_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         keep,
  input logic         keep_l,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         up_stb,
  input logic         dn_stb,
  input logic         ovf_stb,
  input logic         unf_stb
);

  p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_stb && dn_stb));

  p_up_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    up_stb |-> count == W'($past(count) + 1'b1));

  p_dn_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb |-> count == W'($past(count) - 1'b1));

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && keep) |=> ($stable(count) && !up_stb && !dn_stb));

  p_clear_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !keep) |=> (count == '0));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && !keep_l) |=> (count == $past(load_val) && !up_stb && !dn_stb));

  p_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |-> (up_stb && count == '0));

  p_unf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_stb |-> (dn_stb && count == {W{1'b1}}));

endmodule

bind qenc_counter qenc_counter_chk #(.W(W)) u_chk (.*);

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] cnt;
    logic up, dn, ov, un;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, keep = 1'b0, enc_a = 1'b0, enc_b = 1'b0;
  logic [1:0] mode = 2'b00, edge_sel = 2'b00;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic up_stb, dn_stb, ovf_stb, unf_stb;

  always #2.5 clk = ~clk;

  qenc_counter #(.W(W)) u_qenc_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .edge_sel(edge_sel),
    .keep(keep), .load_val(load_val), .enc_a(enc_a), .enc_b(enc_b),
    .count(count), .up_stb(up_stb), .dn_stb(dn_stb),
    .ovf_stb(ovf_stb), .unf_stb(unf_stb)
  );

  int n_chk = 0, n_bad = 0;
  exp_t  q_exp[$];
  string q_tag[$];

  // bench-side expectation state
  logic pa = 0, pb = 0, pen = 0, sk = 0;
  logic [1:0] sm = 0, se = 0;
  logic [W-1:0] cnt = 0;
  logic e_v = 0, k_v = 0;
  logic [1:0] m_v = 0, s_v = 0;
  logic [W-1:0] ld_v = 0;

  task automatic check(input string tag, input exp_t got, input exp_t want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got cnt=%h u%b d%b o%b n%b, expected cnt=%h u%b d%b o%b n%b",
        tag, got.cnt, got.up, got.dn, got.ov, got.un,
        want.cnt, want.up, want.dn, want.ov, want.un);
    end
  endtask

  task automatic cyc(input logic a, input logic b, input string tag);
    logic ar, af, br, bf, av, bv, up, dn, ld;
    logic [1:0] es;
    exp_t x;
    @(negedge clk);
    en = e_v; mode = m_v; edge_sel = s_v; keep = k_v; load_val = ld_v;
    enc_a = a; enc_b = b;
    ar = a & !pa; af = !a & pa; br = b & !pb; bf = !b & pb;
    es = sm[1] ? 2'b11 : se;
    av = (es[0] && ar) || (es[1] && af);
    bv = (es[0] && br) || (es[1] && bf);
    up = 0; dn = 0;
    if (sm == 2'b00) begin up = av && !b; dn = av && b; end
    else if (sm == 2'b01) begin up = av && !bv; dn = bv && !av; end
    else if (sm == 2'b10) begin up = !b && af; dn = !b && ar; end
    else if ((ar || af) != (br || bf)) begin
      up = (ar && !b) || (af && b) || (br && a) || (bf && !a);
      dn = (ar && b) || (af && !b) || (br && !a) || (bf && a);
    end
    ld = e_v && !pen && !sk;
    x = '0;
    if (!e_v) begin
      if (!k_v) cnt = '0;
    end else if (ld) cnt = ld_v;
    else if (up) begin x.up = 1; x.ov = (cnt == '1); cnt = cnt + 1'b1; end
    else if (dn) begin x.dn = 1; x.un = (cnt == '0); cnt = cnt - 1'b1; end
    x.cnt = cnt;
    if (!e_v) begin sm = m_v; se = s_v; sk = k_v; end
    pa = a; pb = b; pen = e_v;
    q_exp.push_back(x);
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() != 0)
        check(q_tag.pop_front(), {count, up_stb, dn_stb, ovf_stb, unf_stb}, q_exp.pop_front());
    end
  end

  initial begin : watchdog
    #500us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {count, up_stb, dn_stb, ovf_stb, unf_stb}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R9 load on enable, rule 0 (R2) with rising edges (R6)
    m_v = 2'b00; s_v = 2'b01; k_v = 0; ld_v = 16'd100; e_v = 0;
    cyc(0, 0, "R8 idle");
    e_v = 1; cyc(0, 0, "R9 load");
    cyc(1, 0, "R2 A rise B low up");
    cyc(0, 0, "R6 fall ignored");
    cyc(1, 1, "R2 A rise B high down");
    cyc(0, 1, "R6 fall ignored");
    cyc(0, 0, "R2 B edge nothing");

    // R8 hold with keep, R9 no load, falling select
    k_v = 1; e_v = 0; cyc(0, 0, "R8 hold");
    s_v = 2'b10; ld_v = 16'd7; cyc(1, 0, "R8 no count off");
    e_v = 1; cyc(1, 0, "R9 keep no load");
    cyc(0, 0, "R6 falling up");
    cyc(1, 0, "R6 rising ignored");
    // R7 change while running
    m_v = 2'b01; s_v = 2'b01; cyc(0, 1, "R7 mode held A fall B high");
    cyc(0, 0, "R7 still rule 0");

    // rule 1, both edges
    e_v = 0; s_v = 2'b11; cyc(0, 0, "R8 reconfig");
    e_v = 1; cyc(0, 0, "R9 keep");
    cyc(1, 0, "R3 A up");
    cyc(1, 1, "R3 B down");
    cyc(0, 0, "R3 both cancel");
    cyc(1, 1, "R3 both cancel rise");
    cyc(1, 0, "R3 B fall down");

    // edge select none
    e_v = 0; s_v = 2'b00; cyc(0, 0, "R8 reconfig");
    e_v = 1; cyc(0, 0, "R9 keep");
    cyc(1, 0, "R6 none");
    cyc(0, 1, "R6 none");
    cyc(0, 0, "R6 none");

    // rule 2, field ignored
    e_v = 0; m_v = 2'b10; cyc(0, 0, "R8 reconfig");
    e_v = 1; cyc(0, 0, "R9 keep");
    cyc(1, 0, "R4 A rise B low down");
    cyc(0, 0, "R4 A fall B low up");
    cyc(0, 1, "R4 B edge nothing");
    cyc(1, 1, "R4 B high ignored");
    cyc(0, 1, "R4 B high ignored");
    cyc(0, 0, "R4 B edge nothing");

    // rule 3
    e_v = 0; m_v = 2'b11; cyc(0, 0, "R8 reconfig");
    e_v = 1; cyc(0, 0, "R9 keep");
    cyc(1, 0, "R5 up1"); cyc(1, 1, "R5 up2");
    cyc(0, 1, "R5 up3"); cyc(0, 0, "R5 up4");
    cyc(0, 1, "R5 dn1"); cyc(1, 1, "R5 dn2");
    cyc(1, 0, "R5 dn3"); cyc(0, 0, "R5 dn4");
    cyc(1, 1, "R5 both ignored");
    cyc(0, 0, "R5 both ignored");

    // R10 wrap both ways
    e_v = 0; k_v = 0; cyc(0, 0, "R8 clear");
    m_v = 2'b01; s_v = 2'b01; ld_v = '1; cyc(0, 0, "R8 clear held");
    e_v = 1; cyc(0, 0, "R9 load max");
    cyc(1, 0, "R10 overflow");
    cyc(0, 0, "R10 idle");
    cyc(0, 1, "R10 underflow");
    cyc(0, 0, "R11 idle");
    e_v = 0; cyc(1, 1, "R8 cleared no count");

    @(posedge clk); #2;
    @(posedge clk); #2;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule